// File: doc/BRIEF.md
# Non-volatile RAM window strobe and acknowledge timer

This block sits between a 68000-style bus master and a non-volatile RAM placed in a single address window. It watches the top three address lines and the address strobe. When an access falls inside the window it drives the chip select low. It drives the read or write strobe low once a data strobe qualifies the transfer direction. The block then answers the bus master with an active-low data-transfer acknowledge, which follows a programmable number of CPU clock periods.

The acknowledge timer is a chain of flip-flops on the CPU clock. A zero enters the first stage on the first rising edge at which the window is selected, and it moves one stage further on each later edge. A three-bit tap setting picks the stage that drives the acknowledge. The integrator sets the tap so that the delay covers both the memory's read-access time and its write-latch time. Accesses outside the window never touch the acknowledge, because other logic on the board answers them.

Top module: `nvack_ack_gen`

## Requirements
- R1: Chip select `cs_n` is low exactly when `as_n` is low, the reset release has completed, and `addr_hi` (A23..A21) equals 3'b100. That window covers byte addresses 0x800000 to 0x9FFFFF.
- R2: When `as_n` is high, or the address is outside the window, `dtack_n` stays high.
- R3: `rd_n` is low only while the window is selected, `rw` is high and at least one of `uds_n`/`lds_n` is low.
- R4: `wr_n` is low only while the window is selected, `rw` is low and at least one of `uds_n`/`lds_n` is low.
- R5: A tap value v (0..7) makes `dtack_n` go low after the (v+1)-th rising edge that samples the window selected. Value 0 therefore gives one clock, the same as registering the address strobe, and value 7 gives eight clocks.
- R6: Once low, `dtack_n` stays low for as long as the selection holds.
- R7: When `as_n` goes high, `dtack_n`, `cs_n`, `rd_n` and `wr_n` are all high in that same cycle. The chain returns to all ones, so the next access counts its delay from zero, even when only one idle cycle separates the two accesses.
- R8: While `rst_n` is low, and for the two edges of reset release, every output is high whatever the bus inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_hi | input | 3 | Address lines A23..A21 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| tap_sel | input | 3 | Acknowledge delay setting, v gives v+1 clocks |
| cs_n | output | 1 | Memory chip select, active low |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
The bound checker runs on every cycle. It checks that the window decode drives the chip select, that no strobe or acknowledge appears outside the window or while the address strobe is high, and that read and write qualify correctly. Using its own count of selected edges, it also checks that the acknowledge is never early and never late for the current tap. Two things need the bench scenarios: the full sweep of all eight tap values, and the restart of the count between back-to-back accesses. So do the partial data strobes, a selection without any data strobe, an address that leaves the window in mid-access, and the output state while reset is held with a selected bus.

// File: rtl/nvack_pkg.sv
package nvack_pkg;

  // Internal active-high view of the memory-side strobes.
  typedef struct packed {
    logic cs;
    logic rd;
    logic wr;
  } nvack_strobe_t;

  // True when either byte lane requests a transfer.
  function automatic logic lane_active(input logic uds_n, input logic lds_n);
    return ~(uds_n & lds_n);
  endfunction

  // Limit a tap setting to the last stage of a chain.
  function automatic int unsigned clamp_tap(input int unsigned tap, input int unsigned depth);
    return (tap > depth - 1) ? depth - 1 : tap;
  endfunction

endpackage

// File: rtl/nvack_rst_sync.sv
module nvack_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nvack_window_decode.sv
module nvack_window_decode
  import nvack_pkg::*;
#(
  parameter int unsigned             WIN_BITS  = 3,
  parameter logic [WIN_BITS-1:0]     WIN_MATCH = 3'b100
) (
  input  logic                ready,
  input  logic [WIN_BITS-1:0] addr_hi,
  input  logic                as_n,
  input  logic                uds_n,
  input  logic                lds_n,
  input  logic                rw,
  output logic                sel,
  output nvack_strobe_t       strb
);

  logic in_window;
  logic lane;

  always_comb begin
    in_window = (addr_hi == WIN_MATCH);
    lane      = lane_active(uds_n, lds_n);
    sel       = ready & ~as_n & in_window;
    strb.cs   = sel;
    strb.rd   = sel & rw & lane;
    strb.wr   = sel & ~rw & lane;
  end

endmodule

// File: rtl/nvack_tap_chain.sv
module nvack_tap_chain
  import nvack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             tap_done
);

  localparam logic [TAP_W-1:0] LAST_IDX = TAP_W'(clamp_tap(DEPTH, DEPTH));

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;
  logic             chain_en;
  logic [TAP_W-1:0] tap_idx;

  // First stage takes a zero while selected; later stages copy their neighbour.
  // A dropped selection forces every stage back to one.
  assign stage_d[0] = ~start;

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    assign stage_d[k] = start ? stage_q[k-1] : 1'b1;
  end

  always_comb begin
    chain_en = start | ~(&stage_q);
    tap_idx  = (tap_sel > LAST_IDX) ? LAST_IDX : tap_sel;
    tap_done = start & ~stage_q[tap_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
    end else if (chain_en) begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/nvack_ack_gen.sv
module nvack_ack_gen
  import nvack_pkg::*;
#(
  parameter int unsigned         WIN_BITS    = 3,
  parameter logic [WIN_BITS-1:0] WIN_MATCH   = 3'b100,
  parameter int unsigned         DEPTH       = 8,
  parameter int unsigned         TAP_W       = $clog2(DEPTH),
  parameter int unsigned         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIN_BITS-1:0] addr_hi,
  input  logic                as_n,
  input  logic                uds_n,
  input  logic                lds_n,
  input  logic                rw,
  input  logic [TAP_W-1:0]    tap_sel,
  output logic                cs_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic                dtack_n
);

  logic          rst_sync_n;
  logic          sel;
  logic          tap_done;
  nvack_strobe_t strb;

  nvack_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nvack_window_decode #(
    .WIN_BITS  (WIN_BITS),
    .WIN_MATCH (WIN_MATCH)
  ) u_decode (
    .ready   (rst_sync_n),
    .addr_hi (addr_hi),
    .as_n    (as_n),
    .uds_n   (uds_n),
    .lds_n   (lds_n),
    .rw      (rw),
    .sel     (sel),
    .strb    (strb)
  );

  nvack_tap_chain #(
    .DEPTH (DEPTH),
    .TAP_W (TAP_W)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (sel),
    .tap_sel  (tap_sel),
    .tap_done (tap_done)
  );

  always_comb begin
    cs_n    = ~strb.cs;
    rd_n    = ~strb.rd;
    wr_n    = ~strb.wr;
    dtack_n = ~tap_done;
  end

endmodule

// File: rtl/nvack_ack_gen_chk.sv
module nvack_ack_gen_chk #(
  parameter int unsigned         WIN_BITS    = 3,
  parameter logic [WIN_BITS-1:0] WIN_MATCH   = 3'b100,
  parameter int unsigned         DEPTH       = 8,
  parameter int unsigned         TAP_W       = $clog2(DEPTH),
  parameter int unsigned         SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WIN_BITS-1:0] addr_hi,
  input logic                as_n,
  input logic                uds_n,
  input logic                lds_n,
  input logic                rw,
  input logic [TAP_W-1:0]    tap_sel,
  input logic                cs_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic                dtack_n
);

  localparam int unsigned CNT_W = TAP_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b1, {TAP_W{1'b0}}};

  logic [SYNC_STAGES-1:0] settle_q;
  logic                   settled;
  logic                   picked;
  logic [CNT_W-1:0]       edges_q;
  logic [CNT_W-1:0]       tap_ext;

  assign settled = settle_q[SYNC_STAGES-1];
  assign picked  = settled && !as_n && (addr_hi == WIN_MATCH);
  assign tap_ext = {1'b0, tap_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      edges_q  <= '0;
    end else begin
      settle_q <= {settle_q[SYNC_STAGES-2:0], 1'b1};
      if (!picked) begin
        edges_q <= '0;
      end else if (edges_q != CNT_MAX) begin
        edges_q <= edges_q + 1'b1;
      end
    end
  end

  p_cs_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (cs_n == !picked));

  p_no_ack_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || addr_hi != WIN_MATCH) |-> dtack_n);

  p_rd_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!cs_n && rw && (!uds_n || !lds_n)));

  p_wr_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_n && !rw && (!uds_n || !lds_n)));

  p_never_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (edges_q > tap_ext));

  p_never_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (picked && edges_q > tap_ext) |-> !dtack_n);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (dtack_n && cs_n && rd_n && wr_n));

  p_ack_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(!as_n));

  p_settle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (dtack_n && cs_n && rd_n && wr_n));

endmodule

bind nvack_ack_gen nvack_ack_gen_chk #(
  .WIN_BITS    (WIN_BITS),
  .WIN_MATCH   (WIN_MATCH),
  .DEPTH       (DEPTH),
  .TAP_W       (TAP_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr_hi (addr_hi),
  .as_n    (as_n),
  .uds_n   (uds_n),
  .lds_n   (lds_n),
  .rw      (rw),
  .tap_sel (tap_sel),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .dtack_n (dtack_n)
);

// File: tb/nvack_ack_gen_tb.sv
module nvack_ack_gen_tb;

  logic       clk;
  logic       rst_n;
  logic [2:0] addr_hi;
  logic       as_n;
  logic       uds_n;
  logic       lds_n;
  logic       rw;
  logic [2:0] tap_sel;
  logic       cs_n;
  logic       rd_n;
  logic       wr_n;
  logic       dtack_n;

  int    n_checks = 0;
  int    n_fails  = 0;
  string tag      = "R8";
  bit    finished = 0;

  // Reference state: edges since reset release, edges with the window selected.
  int rel_edges = 0;
  int sel_edges = 0;

  nvack_ack_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_hi (addr_hi),
    .as_n    (as_n),
    .uds_n   (uds_n),
    .lds_n   (lds_n),
    .rw      (rw),
    .tap_sel (tap_sel),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .dtack_n (dtack_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit model_sel();
    return rst_n && (rel_edges >= 2) && !as_n && (addr_hi == 3'b100);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_edges <= 0;
      sel_edges <= 0;
    end else begin
      sel_edges <= model_sel() ? sel_edges + 1 : 0;
      if (rel_edges < 4) rel_edges <= rel_edges + 1;
    end
  end

  task automatic check_bit(input string what, input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Compare every output shortly after inputs settle in each low phase.
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      bit s, lane;
      s    = model_sel();
      lane = !uds_n || !lds_n;
      check_bit("cs_n",    (tag == "R8") ? "R8" : "R1", cs_n, !s);
      check_bit("rd_n",    (tag == "R8") ? "R8" : "R3", rd_n, !(s && rw && lane));
      check_bit("wr_n",    (tag == "R8") ? "R8" : "R4", wr_n, !(s && !rw && lane));
      check_bit("dtack_n", tag, dtack_n, !(s && sel_edges >= int'(tap_sel) + 1));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      as_n  = 1'b1;
      uds_n = 1'b1;
      lds_n = 1'b1;
    end
  endtask

  task automatic access(input string tg, input logic [2:0] a, input logic dir,
                        input logic u, input logic l, input logic [2:0] tap, input int hold);
    @(negedge clk);
    tag     = tg;
    addr_hi = a;
    rw      = dir;
    uds_n   = u;
    lds_n   = l;
    tap_sel = tap;
    as_n    = 1'b0;
    for (int i = 1; i < hold; i++) @(negedge clk);
    as_n  = 1'b1;
    uds_n = 1'b1;
    lds_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    addr_hi = 3'b100;
    as_n    = 1'b0;
    uds_n   = 1'b0;
    lds_n   = 1'b0;
    rw      = 1'b1;
    tap_sel = 3'd0;
    // R8: selected bus during reset leaves every output high
    tag = "R8";
    repeat (3) @(negedge clk);
    as_n  = 1'b1;
    uds_n = 1'b1;
    lds_n = 1'b1;
    rst_n = 1'b1;
    idle(5);

    // R5 R6: every tap value on a read, held past the delay
    for (int t = 0; t < 8; t++) begin
      access("R5", 3'b100, 1'b1, 1'b0, 1'b0, 3'(t), t + 4);
      idle(1);
    end

    // R4: writes, both lanes and lower lane alone
    access("R5", 3'b100, 1'b0, 1'b0, 1'b0, 3'd2, 6);
    idle(1);
    access("R6", 3'b100, 1'b0, 1'b1, 1'b0, 3'd4, 9);
    idle(1);
    // R3: read on the upper lane alone
    access("R6", 3'b100, 1'b1, 1'b0, 1'b1, 3'd1, 5);
    idle(1);
    // R1: selection with no data strobe still selects and acknowledges
    access("R5", 3'b100, 1'b1, 1'b1, 1'b1, 3'd3, 7);
    idle(1);

    // R2: neighbours of the window, below and above
    access("R2", 3'b011, 1'b1, 1'b0, 1'b0, 3'd0, 6);
    idle(1);
    access("R2", 3'b101, 1'b0, 1'b0, 1'b0, 3'd0, 6);
    idle(1);

    // R7: back-to-back accesses separated by one idle cycle restart the count
    access("R7", 3'b100, 1'b1, 1'b0, 1'b0, 3'd5, 9);
    access("R7", 3'b100, 1'b1, 1'b0, 1'b0, 3'd5, 9);
    access("R7", 3'b100, 1'b0, 1'b0, 1'b0, 3'd6, 4);
    idle(2);

    // R7: address leaves the window during an acknowledged access
    @(negedge clk);
    tag = "R7"; addr_hi = 3'b100; rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
    tap_sel = 3'd1; as_n = 1'b0;
    repeat (4) @(negedge clk);
    addr_hi = 3'b110;
    repeat (2) @(negedge clk);
    addr_hi = 3'b100;
    repeat (4) @(negedge clk);
    idle(3);

    // R8: reset asserted mid-access forces everything high
    @(negedge clk);
    tag = "R8"; tap_sel = 3'd0; as_n = 1'b0; uds_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(3);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule